// File: doc/BRIEF.md
# Scan Pattern Load-Capture-Unload Sequencer

This block is a small on-chip tester for a single scan chain of `CHAIN_LEN` cells. Patterns arrive over a valid/ready handshake. Each pattern carries a stimulus word and the response word the chain should hold after one functional clock. For each pattern the block runs three phases. It first shifts the stimulus into the chain with the chain's scan-enable high. It then drops scan-enable for a single capture clock. Finally it shifts the captured response back out and compares it with the expected word.

When a new pattern is accepted while a response still has to come out, the block overlaps the two. The stimulus of the new pattern enters on `chain_si` during the same shift pass that carries the old response out on `chain_so`. Only the first pattern of a burst needs a pass of its own to load. When nothing follows, the last unload pushes zeros into the chain. After every unload the block raises a one-cycle result strobe with a pass flag. A saturating counter totals the failing patterns.

Top module: `scan_lcu_seq`

## Requirements
- R1: While and right after the synchronous active-high reset, `chain_se` is 0, `pat_ready` is 1, `res_valid` is 0 and `fail_count` is 0.
- R2: A pattern accepted while idle starts a shift pass in the next cycle. `chain_se` is 1 for exactly `CHAIN_LEN` cycles, and in shift cycle k `chain_si` carries stimulus bit `CHAIN_LEN-1-k`, so the most-significant bit goes first.
- R3: Every shift pass that loads a stimulus is followed by exactly one cycle with `chain_se` at 0 (the capture cycle), and then a new shift pass.
- R4: The pass after a capture unloads. `chain_so` is sampled on each of its `CHAIN_LEN` rising edges. The first bit sampled becomes bit `CHAIN_LEN-1` of the response and the last becomes bit 0.
- R5: A pattern accepted in the last cycle of a pass that loads a stimulus is shifted in during the next pass, which also unloads the previous response. In a continuous burst the result strobes are `CHAIN_LEN+1` cycles apart.
- R6: An unload pass with no pending pattern drives `chain_si` to 0 in every cycle, so the chain holds all zeros when it ends. The block then goes idle with `chain_se` at 0.
- R7: One cycle after the last rising edge of an unload pass, `res_valid` is 1 for one cycle. `res_pass` is 1 exactly when the assembled response equals the expected word of that pattern.
- R8: `fail_count` goes up by one with each strobe whose `res_pass` is 0. It holds at its maximum value, all ones, and changes at no other time.
- R9: `pat_ready` is 1 only while idle or in the last cycle of a shift pass. It is 0 in the capture cycle and in every other shift cycle.
- R10: A pattern accepted in the last cycle of an unload-only pass starts its load pass straight away. `chain_se` stays 1 across the boundary, so the two result strobes are `2*CHAIN_LEN+1` cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pat_valid | input | 1 | A pattern is offered on `pat_stim`/`pat_expect` |
| pat_ready | output | 1 | The block takes the offered pattern on this edge |
| pat_stim | input | CHAIN_LEN | Stimulus word; bit i ends up in chain cell i |
| pat_expect | input | CHAIN_LEN | Response expected after the capture clock |
| chain_se | output | 1 | Scan-enable to the chain: 1 shifts, 0 captures |
| chain_si | output | 1 | Serial data into the first chain cell |
| chain_so | input | 1 | Serial data from the last chain cell |
| res_valid | output | 1 | One-cycle strobe when a response has been compared |
| res_pass | output | 1 | Compare outcome, meaningful while `res_valid` is 1 |
| fail_count | output | CNT_W | Saturating count of failing patterns |

## Verification
The assertions assume that `chain_so` comes from a mux-scan chain of exactly `CHAIN_LEN` cells clocked by `clk`. The chain must shift when `chain_se` is 1 and load its functional data when it is 0. They also assume that `pat_stim` and `pat_expect` stay steady while `pat_valid` is high and the pattern has not yet been accepted. The bench satisfies the first assumption with a behavioural chain of that length whose functional data is a fixed rotate-and-invert of its own contents. It satisfies the second by driving the handshake at falling edges and releasing `pat_valid` only after the accepting edge. The bench also takes care over the interval between bursts. It lets the block reach idle, or times a new offer so that it falls in the last cycle of an unload-only pass, so that both the pipelined and the restarted sequences are exercised.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_CAPT  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/scan_seq_ctrl.sv
// Phase controller: sequences shift passes and capture cycles and owns the handshake.
module scan_seq_ctrl
    import scan_seq_pkg::*;
#(
    parameter int CHAIN_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic pat_valid,
    output logic pat_ready,
    output logic accept,
    output logic shift_act,
    output logic last_cyc,
    output logic load_act,
    output logic unload_act
);
    localparam int CW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(CHAIN_LEN - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic          load;    // current pass carries a stimulus
        logic          unload;  // current pass carries a response
        logic          pend;    // a stimulus waits for the pass after capture
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        pat_ready = (ctl_q.state == ST_IDLE) ||
                    (ctl_q.state == ST_SHIFT && ctl_q.cnt == LAST);
        accept    = pat_valid && pat_ready;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.state  = ST_SHIFT;
                    ctl_d.cnt    = '0;
                    ctl_d.load   = 1'b1;
                    ctl_d.unload = 1'b0;
                end
            end
            ST_SHIFT: begin
                if (ctl_q.cnt == LAST) begin
                    ctl_d.cnt  = '0;
                    ctl_d.pend = accept;
                    if (ctl_q.load) begin
                        ctl_d.state = ST_CAPT;
                    end else if (accept) begin
                        ctl_d.state  = ST_SHIFT;
                        ctl_d.load   = 1'b1;
                        ctl_d.unload = 1'b0;
                    end else begin
                        ctl_d.state  = ST_IDLE;
                        ctl_d.load   = 1'b0;
                        ctl_d.unload = 1'b0;
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_CAPT: begin
                ctl_d.state  = ST_SHIFT;
                ctl_d.cnt    = '0;
                ctl_d.unload = 1'b1;
                ctl_d.load   = ctl_q.pend;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{state: ST_IDLE, cnt: '0, load: 1'b0, unload: 1'b0, pend: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign shift_act  = (ctl_q.state == ST_SHIFT);
    assign last_cyc   = shift_act && (ctl_q.cnt == LAST);
    assign load_act   = ctl_q.load;
    assign unload_act = ctl_q.unload;

    // R3: capture lasts exactly one cycle and a fresh pass follows it
    p_capt_single_r3: assert property (@(posedge clk) disable iff (rst)
        ctl_q.state == ST_CAPT |=> ctl_q.state == ST_SHIFT && ctl_q.cnt == '0 && ctl_q.unload);

    // R2: a pass advances one count per cycle until its last cycle
    p_pass_steps_r2: assert property (@(posedge clk) disable iff (rst)
        ctl_q.state == ST_SHIFT && ctl_q.cnt != LAST
        |=> ctl_q.state == ST_SHIFT && ctl_q.cnt == $past(ctl_q.cnt) + 1'b1);

    // R6: an unload-only pass with no new offer returns to idle
    p_final_idle_r6: assert property (@(posedge clk) disable iff (rst)
        last_cyc && !ctl_q.load && !pat_valid |=> ctl_q.state == ST_IDLE);

    // R10: a pattern taken at the end of an unload-only pass loads at once
    p_restart_load_r10: assert property (@(posedge clk) disable iff (rst)
        last_cyc && !ctl_q.load && accept |=> ctl_q.state == ST_SHIFT && ctl_q.load && !ctl_q.unload);
endmodule

// File: rtl/scan_seq_stim.sv
// Stimulus shifter: holds the word being loaded and presents it MSB first.
module scan_seq_stim #(
    parameter int CHAIN_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 accept,
    input  logic [CHAIN_LEN-1:0] pat_stim,
    input  logic                 shift_act,
    input  logic                 load_act,
    output logic                 chain_si
);
    logic [CHAIN_LEN-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (accept) begin
            sr_d = pat_stim;
        end else if (shift_act) begin
            sr_d = sr_q << 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign chain_si = (shift_act && load_act) ? sr_q[CHAIN_LEN-1] : 1'b0;

    // R2: an accepted word is what the next pass starts from
    p_word_taken_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> sr_q == $past(pat_stim));
endmodule

// File: rtl/scan_seq_resp.sv
// Response collector: assembles the unloaded bits, compares, counts failures.
module scan_seq_resp #(
    parameter int CHAIN_LEN = 8,
    parameter int CNT_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 accept,
    input  logic [CHAIN_LEN-1:0] pat_expect,
    input  logic                 shift_act,
    input  logic                 last_cyc,
    input  logic                 load_act,
    input  logic                 unload_act,
    input  logic                 chain_so,
    output logic                 res_valid,
    output logic                 res_pass,
    output logic [CNT_W-1:0]     fail_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CHAIN_LEN-1:0] resp;
        logic [CHAIN_LEN-1:0] exp_load;  // expected word of the stimulus being loaded
        logic [CHAIN_LEN-1:0] exp_chk;   // expected word of the response in the chain
        logic                 valid;
        logic                 pass;
        logic [CNT_W-1:0]     fails;
    } resp_t;

    resp_t rs_d, rs_q;
    logic [CHAIN_LEN:0]   cat;
    logic [CHAIN_LEN-1:0] full;

    always_comb begin
        cat      = {rs_q.resp, chain_so};
        full     = cat[CHAIN_LEN-1:0];
        rs_d     = rs_q;
        rs_d.valid = 1'b0;
        if (accept) begin
            rs_d.exp_load = pat_expect;
        end
        if (shift_act && unload_act) begin
            rs_d.resp = full;
            if (last_cyc) begin
                rs_d.valid = 1'b1;
                rs_d.pass  = (full == rs_q.exp_chk);
                if (full != rs_q.exp_chk && rs_q.fails != CNT_MAX) begin
                    rs_d.fails = rs_q.fails + 1'b1;
                end
            end
        end
        if (last_cyc && load_act) begin
            rs_d.exp_chk = rs_q.exp_load;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign res_valid  = rs_q.valid;
    assign res_pass   = rs_q.pass;
    assign fail_count = rs_q.fails;

    // R7: the result strobe is a single-cycle pulse
    p_strobe_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R8: the counter moves only on a failing strobe, and then by one
    p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
        fail_count != $past(fail_count)
        |-> res_valid && !res_pass && fail_count == CNT_W'($past(fail_count) + 1'b1));
endmodule

// File: rtl/scan_lcu_seq.sv
module scan_lcu_seq #(
    parameter int CHAIN_LEN = 8,
    parameter int CNT_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pat_valid,
    output logic                 pat_ready,
    input  logic [CHAIN_LEN-1:0] pat_stim,
    input  logic [CHAIN_LEN-1:0] pat_expect,
    output logic                 chain_se,
    output logic                 chain_si,
    input  logic                 chain_so,
    output logic                 res_valid,
    output logic                 res_pass,
    output logic [CNT_W-1:0]     fail_count
);
    logic accept, shift_act, last_cyc, load_act, unload_act;

    scan_seq_ctrl #(.CHAIN_LEN(CHAIN_LEN)) u_ctrl (
        .clk(clk), .rst(rst), .pat_valid(pat_valid), .pat_ready(pat_ready),
        .accept(accept), .shift_act(shift_act), .last_cyc(last_cyc),
        .load_act(load_act), .unload_act(unload_act)
    );

    scan_seq_stim #(.CHAIN_LEN(CHAIN_LEN)) u_stim (
        .clk(clk), .rst(rst), .accept(accept), .pat_stim(pat_stim),
        .shift_act(shift_act), .load_act(load_act), .chain_si(chain_si)
    );

    scan_seq_resp #(.CHAIN_LEN(CHAIN_LEN), .CNT_W(CNT_W)) u_resp (
        .clk(clk), .rst(rst), .accept(accept), .pat_expect(pat_expect),
        .shift_act(shift_act), .last_cyc(last_cyc), .load_act(load_act),
        .unload_act(unload_act), .chain_so(chain_so), .res_valid(res_valid),
        .res_pass(res_pass), .fail_count(fail_count)
    );

    assign chain_se = shift_act;

    // R9: no offer is taken during a capture cycle
    p_no_take_in_capt_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(chain_se) && $past(load_act) |-> !pat_ready);
endmodule

// File: tb/sim_scan_lcu_seq.sv
module sim_scan_lcu_seq;
    localparam int N  = 8;
    localparam int CW = 3;
    localparam logic [N-1:0] FMASK = 8'hC3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pat_valid = 1'b0;
    logic pat_ready;
    logic [N-1:0] pat_stim = '0;
    logic [N-1:0] pat_expect = '0;
    logic chain_se, chain_si, chain_so;
    logic res_valid, res_pass;
    logic [CW-1:0] fail_count;
    logic [N-1:0] chain = '0;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int model_fails = 0;
    bit exp_q[$];
    int stamps[$];

    always #10 clk = ~clk;

    scan_lcu_seq #(.CHAIN_LEN(N), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .pat_valid(pat_valid), .pat_ready(pat_ready),
        .pat_stim(pat_stim), .pat_expect(pat_expect), .chain_se(chain_se),
        .chain_si(chain_si), .chain_so(chain_so), .res_valid(res_valid),
        .res_pass(res_pass), .fail_count(fail_count)
    );

    // Behavioural mux-scan chain: cell 0 takes chain_si, cell N-1 drives chain_so
    function automatic logic [N-1:0] func_of(logic [N-1:0] v);
        return {v[N-2:0], v[N-1]} ^ FMASK;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (chain_se) chain <= {chain[N-2:0], chain_si};
        else          chain <= func_of(chain);
    end
    assign chain_so = chain[N-1];

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Driver: offers one pattern, returns at the falling edge after acceptance
    task automatic send(input logic [N-1:0] stim, input logic [N-1:0] expv);
        @(negedge clk);
        pat_valid  = 1'b1;
        pat_stim   = stim;
        pat_expect = expv;
        while (!pat_ready) @(negedge clk);
        exp_q.push_back(expv == func_of(stim));
        @(negedge clk);
        pat_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard on each result strobe (R7, R8)
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected strobe", 1, 0);
            end else begin
                bit e;
                e = exp_q.pop_front();
                chk(res_pass == e, "R7 pass flag", res_pass, e);
                if (!e && model_fails < (1 << CW) - 1) model_fails++;
                chk(fail_count == model_fails[CW-1:0], "R8 fail count", fail_count, model_fails);
                stamps.push_back(cyc);
            end
        end
    end

    initial begin
        repeat ((1 << 17)) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [N-1:0] s;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(chain_se == 1'b0, "R1 se in reset", chain_se, 0);
        chk(pat_ready == 1'b1, "R1 ready in reset", pat_ready, 1);
        chk(res_valid == 1'b0, "R1 strobe in reset", res_valid, 0);
        chk(fail_count == '0, "R1 count in reset", fail_count, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(chain_se == 1'b0 && pat_ready == 1'b1, "R1 idle after reset", chain_se, 0);

        // Directed single pattern: phase timing, bit order, zero fill
        s = 8'hB4;
        send(s, func_of(s));
        for (int i = 0; i < N; i++) begin
            chk(chain_se == 1'b1, "R2 se during load", chain_se, 1);
            chk(chain_si == s[N-1-i], "R2 msb-first bit", chain_si, s[N-1-i]);
            chk(pat_ready == (i == N-1), "R9 ready in load pass", pat_ready, i == N-1);
            @(negedge clk);
        end
        chk(chain_se == 1'b0, "R3 capture cycle", chain_se, 0);
        chk(pat_ready == 1'b0, "R9 ready in capture", pat_ready, 0);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            chk(chain_se == 1'b1, "R4 se during unload", chain_se, 1);
            chk(chain_si == 1'b0, "R6 zero fill", chain_si, 0);
            @(negedge clk);
        end
        chk(chain_se == 1'b0, "R6 idle after final unload", chain_se, 0);
        chk(chain == '0, "R6 chain all zeros", chain, 0);
        drain();

        // Burst of pipelined patterns, mixed pass and fail
        stamps.delete();
        send(8'h01, func_of(8'h01));
        send(8'h80, func_of(8'h80));
        send(8'hFF, 8'h00);
        send(8'h5A, func_of(8'h5A));
        send(8'h00, func_of(8'h00));
        drain();
        chk(stamps.size() == 5, "R5 burst strobes", stamps.size(), 5);
        for (int k = 0; k + 1 < stamps.size(); k++)
            chk(stamps[k+1] - stamps[k] == N + 1, "R5 pipelined spacing",
                stamps[k+1] - stamps[k], N + 1);

        // Offer arriving in the last cycle of an unload-only pass
        stamps.delete();
        send(8'h3C, func_of(8'h3C));
        repeat (N + 1) @(negedge clk);
        send(8'hE1, func_of(8'hE1));
        drain();
        chk(stamps.size() == 2, "R10 strobes", stamps.size(), 2);
        if (stamps.size() == 2)
            chk(stamps[1] - stamps[0] == 2 * N + 1, "R10 restart spacing",
                stamps[1] - stamps[0], 2 * N + 1);

        // Saturation of the failure counter
        for (int k = 0; k < 10; k++) begin
            s = N'(k * 37 + 5);
            send(s, ~func_of(s));
        end
        drain();
        chk(fail_count == '1, "R8 saturated count", fail_count, (1 << CW) - 1);
        send(8'h77, ~func_of(8'h77));
        drain();
        chk(fail_count == '1, "R8 holds at max", fail_count, (1 << CW) - 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule